// File: doc/BRIEF.md
# Interrupt Mask Controller with Set/Clear Registers

This block is the register side of an interrupt controller serving 64 sources. Each clock it samples a 64-bit raw request vector into a flag register. A 64-bit mask register decides which flags may raise the single interrupt-request output. A mask bit of 1 blocks its source and a 0 lets it through. Software can read or write the mask as two 32-bit words.

Software can also change the mask one bit at a time, with no read-modify-write. It writes a byte to a set port or a clear port. The byte holds a 6-bit source index, or a flag that acts on all 64 bits at once. A software acknowledge register reports the active vector. This is the lowest-numbered unmasked pending source plus a base of 64, or zero when no source qualifies.

The bus is a plain byte-addressed register port. Writes are captured on the rising clock edge while the write enable is high. Read data is combinational from the address. Byte-wide ports take their value from `bus_wdata[7:0]`.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is applied and after it, until the first write, every mask bit is 1, every flag bit is 0 and `irq_req` is low.
- R2: Flag bit i equals `irq_in[i]` as sampled at the previous rising edge. Offset 0x10 reads flags 63:32 and offset 0x14 reads flags 31:0. Writes to these offsets have no effect.
- R3: Offset 0x08 writes and reads mask 63:32, and offset 0x0C writes and reads mask 31:0. A write to either word leaves the other word unchanged.
- R4: A write to offset 0x1C with `bus_wdata[6]`=0 sets only mask bit `bus_wdata[5:0]`, for any index 0 to 63. Every other mask bit stays as it was.
- R5: A write to offset 0x1C with `bus_wdata[6]`=1 sets all 64 mask bits, whatever bits 5:0 hold.
- R6: A write to offset 0x1D with `bus_wdata[6]`=0 clears only mask bit `bus_wdata[5:0]`, for any index 0 to 63. Every other mask bit stays as it was.
- R7: A write to offset 0x1D with `bus_wdata[6]`=1 clears all 64 mask bits, whatever bits 5:0 hold.
- R8: Reads of offsets 0x1C and 0x1D always return zero.
- R9: `irq_req` is high exactly when at least one flag bit is 1 while its mask bit is 0.
- R10: A read of offset 0xE0 returns 64 plus the lowest index whose flag is 1 and whose mask is 0. It returns 0 when no such index exists.
- R11: A write to an undefined offset changes neither mask nor flags. A read of an undefined offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable, captured on the rising edge |
| bus_wdata | input | 32 | Write data; byte ports use bits 7:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 64 | Raw interrupt request per source |
| irq_req | output | 1 | Masked interrupt request |

## Verification
A wrong mask bit shows up at the ports one cycle after the write that produced it. It appears in the readback of the affected mask word, in `irq_req` whenever that source is pending, and in the vector returned at 0xE0. A single-bit set or clear that uses a 32-bit shift corrupts indices 32 to 63. The stimulus therefore targets indices in the upper word and reads back the upper word. A flag-capture fault shows in the flag words and in `irq_req` one edge after `irq_in` changes.

// File: rtl/irq_mask_pkg.sv
// Package: shared offsets, control-byte fields and decoded strobes for the
// interrupt mask controller. Assumes a byte-addressed 8-bit register space.
package irq_mask_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLAG_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FLAG_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SET_BYTE = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CLR_BYTE = 8'h1D;
    localparam logic [ADDR_W-1:0] OFS_ACK_VEC = 8'hE0;

    // Bit of the control byte that selects the whole-mask action.
    localparam int CTL_ALL_BIT = 6;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MASK_HI,
        RSEL_MASK_LO,
        RSEL_FLAG_HI,
        RSEL_FLAG_LO,
        RSEL_ACK
    } rsel_e;

    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        logic wr_set;
        logic wr_clr;
    } wstrb_t;
endpackage

// File: rtl/irq_reg_decode.sv
// Address decoder: turns a bus address and write enable into write strobes
// and a read selector. Assumes one access per cycle; undefined offsets
// produce no strobe and select RSEL_NONE.
module irq_reg_decode
    import irq_mask_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wstrb_t            wstrb,
    output rsel_e             rsel
);
    // Write strobes: one per writable offset, gated by the enable.
    always_comb begin
        wstrb        = '0;
        wstrb.wr_hi  = we && (addr == OFS_MASK_HI);
        wstrb.wr_lo  = we && (addr == OFS_MASK_LO);
        wstrb.wr_set = we && (addr == OFS_SET_BYTE);
        wstrb.wr_clr = we && (addr == OFS_CLR_BYTE);
    end

    // Read selector: byte ports and unknown offsets both read as none.
    always_comb begin
        case (addr)
            OFS_MASK_HI: rsel = RSEL_MASK_HI;
            OFS_MASK_LO: rsel = RSEL_MASK_LO;
            OFS_FLAG_HI: rsel = RSEL_FLAG_HI;
            OFS_FLAG_LO: rsel = RSEL_FLAG_LO;
            OFS_ACK_VEC: rsel = RSEL_ACK;
            default:     rsel = RSEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Mask register: NSRC bits split into NSRC/DATA_W words that are written
// whole, plus single-bit and all-bit set/clear from a control byte.
// Assumes NSRC is a multiple of DATA_W and that at most one strobe fires.
module irq_mask_reg
    import irq_mask_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wstrb_t            wstrb,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   mask_q
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int NWORD = NSRC / DATA_W;

    logic [NSRC-1:0]  word_next;
    logic [NSRC-1:0]  one_hot;
    logic [IDX_W-1:0] idx;
    logic             all_sel;

    assign idx     = wdata[IDX_W-1:0];
    assign all_sel = wdata[CTL_ALL_BIT];
    // Full-width shift so that every index reaches its bit.
    assign one_hot = {{(NSRC-1){1'b0}}, 1'b1} << idx;

    // Word writes: word 1 (upper) via wr_hi, word 0 via wr_lo.
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic hit;
        assign hit = (w == NWORD - 1) ? wstrb.wr_hi : (w == 0) ? wstrb.wr_lo : 1'b0;
        assign word_next[w*DATA_W +: DATA_W] = hit ? wdata : mask_q[w*DATA_W +: DATA_W];
    end

    // Register update: reset masks everything, byte ports win over words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wstrb.wr_set) begin
            mask_q <= all_sel ? '1 : (mask_q | one_hot);
        end else if (wstrb.wr_clr) begin
            mask_q <= all_sel ? '0 : (mask_q & ~one_hot);
        end else begin
            mask_q <= word_next;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Lowest-index finder: reports whether any input bit is set and the index
// of the lowest set bit. Purely combinational; index is 0 when none is set.
module irq_prio_enc #(
    parameter int N = 64
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = ($clog2(N))'(i);
            end
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Interrupt mask controller top: samples raw requests into a flag register,
// applies the mask, drives the request output and serves register reads.
// Assumes NSRC == 2*DATA_W so the mask and flags each occupy two words.
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int DATA_W   = 32,
    parameter int VEC_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic              irq_req
);
    localparam int IDX_W = $clog2(NSRC);

    wstrb_t            wstrb;
    rsel_e             rsel;
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   flags_q;
    logic [NSRC-1:0]   live;
    logic              any_live;
    logic [IDX_W-1:0]  live_idx;
    logic [DATA_W-1:0] active_vec;

    irq_reg_decode u_dec (
        .addr  (bus_addr),
        .we    (bus_we),
        .wstrb (wstrb),
        .rsel  (rsel)
    );

    irq_mask_reg #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wstrb  (wstrb),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    // Flag capture: one-cycle sample of the raw request vector.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= irq_in;
    end

    assign live    = flags_q & ~mask_q;
    assign irq_req = |live;

    irq_prio_enc #(.N(NSRC)) u_enc (
        .req   (live),
        .found (any_live),
        .idx   (live_idx)
    );

    assign active_vec = any_live ? (DATA_W'(VEC_BASE) + DATA_W'(live_idx)) : '0;

    // Read mux: undefined and write-only offsets return zero.
    always_comb begin
        case (rsel)
            RSEL_MASK_HI: bus_rdata = mask_q[NSRC-1:DATA_W];
            RSEL_MASK_LO: bus_rdata = mask_q[DATA_W-1:0];
            RSEL_FLAG_HI: bus_rdata = flags_q[NSRC-1:DATA_W];
            RSEL_FLAG_LO: bus_rdata = flags_q[DATA_W-1:0];
            RSEL_ACK:     bus_rdata = active_vec;
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Checker for irq_mask_ctrl: temporal properties on the mask register, the
// request output and read data. Bound to every instance of the top.
module irq_mask_ctrl_chk
    import irq_mask_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_req,
    input logic [NSRC-1:0]   mask_q
);
    localparam int IDX_W = $clog2(NSRC);
    localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

    // R4: single set touches only the indexed bit.
    assert_set_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET_BYTE && !bus_wdata[CTL_ALL_BIT])
        |=> (mask_q == ($past(mask_q) | (ONE << $past(bus_wdata[IDX_W-1:0])))));

    // R5: set-all leaves every bit at 1.
    assert_set_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET_BYTE && bus_wdata[CTL_ALL_BIT])
        |=> (&mask_q));

    // R6: single clear touches only the indexed bit.
    assert_clr_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR_BYTE && !bus_wdata[CTL_ALL_BIT])
        |=> (mask_q == ($past(mask_q) & ~(ONE << $past(bus_wdata[IDX_W-1:0])))));

    // R7: clear-all leaves every bit at 0.
    assert_clr_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR_BYTE && bus_wdata[CTL_ALL_BIT])
        |=> (mask_q == '0));

    // R3: a low-word write keeps the upper word.
    assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MASK_LO)
        |=> (mask_q[NSRC-1:DATA_W] == $past(mask_q[NSRC-1:DATA_W])));

    // R8: byte ports are write-only.
    assert_byte_ports_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_SET_BYTE || bus_addr == OFS_CLR_BYTE) |-> (bus_rdata == '0));

    // R10: no request means the acknowledge vector is zero.
    assert_ack_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_ACK_VEC && !irq_req) |-> (bus_rdata == '0));

    // R11: a write elsewhere leaves the mask unchanged.
    assert_undef_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != OFS_MASK_HI && bus_addr != OFS_MASK_LO &&
         bus_addr != OFS_SET_BYTE && bus_addr != OFS_CLR_BYTE)
        |=> $stable(mask_q));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .mask_q    (mask_q)
);

// File: tb/sim_irq_mask_ctrl.sv
// Scoreboard bench: driver tasks push expected items, a negedge monitor
// pops and compares them against the ports.
module sim_irq_mask_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_in = '0;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [63:0] m_mask = '1;
    logic [63:0] m_flag = '0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    irq_mask_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_req(irq_req)
    );

    // Monitor: compare every queued item half a cycle after it is driven.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_req} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] exp_vec();
        logic [63:0] lv;
        lv = m_flag & ~m_mask;
        for (int i = 63; i >= 0; i--) begin
            if (lv[i]) exp_vec = 32'd64 + 32'(i);
        end
        if (lv == '0) exp_vec = '0;
    endfunction

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        bus_we = 1'b0;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic chk_irq(input string t);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'b0, |(m_flag & ~m_mask)}; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        case (a)
            8'h08: m_mask[63:32] = d;
            8'h0C: m_mask[31:0] = d;
            8'h1C: m_mask = d[6] ? '1 : (m_mask | (64'd1 << d[5:0]));
            8'h1D: m_mask = d[6] ? '0 : (m_mask & ~(64'd1 << d[5:0]));
            default: ;
        endcase
    endtask

    task automatic set_irq(input logic [63:0] v);
        @(posedge clk); #1;
        irq_in = v;
        @(posedge clk); #1;
        m_flag = v;
    endtask

    task automatic all_state(input string t);
        rd(8'h08, m_mask[63:32], t);
        rd(8'h0C, m_mask[31:0], t);
        rd(8'h10, m_flag[63:32], t);
        rd(8'h14, m_flag[31:0], t);
        chk_irq("R9");
        rd(8'hE0, exp_vec(), "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset values seen while reset is held
        rd(8'h08, 32'hFFFF_FFFF, "R1");
        rd(8'h14, 32'h0, "R1");
        @(posedge clk); #1;
        rst_n = 1'b1;
        all_state("R1");

        // R3: low word write keeps upper word
        wr(8'h0C, 32'h0000_0000);
        all_state("R3");

        // R2: flag capture, both words
        set_irq(64'h8000_0001_0000_0010);
        all_state("R2");

        // R4: single set, low index
        wr(8'h1C, 32'h04);
        all_state("R4");

        // R6: single clear in upper word
        wr(8'h1D, 32'h20);
        all_state("R6");
        wr(8'h1D, 32'h3F);
        all_state("R6");

        // R4: single set of index 63
        wr(8'h1C, 32'h3F);
        all_state("R4");

        // R8: byte ports read zero
        rd(8'h1C, 32'h0, "R8");
        rd(8'h1D, 32'h0, "R8");

        // R7: clear-all ignores index bits
        wr(8'h1D, 32'h45);
        all_state("R7");

        // R5: set-all ignores index bits
        wr(8'h1C, 32'h5A);
        all_state("R5");

        // R3: upper word write keeps lower word
        wr(8'h08, 32'h0000_00FF);
        all_state("R3");

        // R11: undefined and read-only offsets ignore writes
        wr(8'h14, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        all_state("R11");
        rd(8'h30, 32'h0, "R11");
        rd(8'h04, 32'h0, "R11");

        // R10: lowest pending wins among several
        wr(8'h1D, 32'h40);
        set_irq(64'h0000_0100_0000_0000);
        all_state("R10");
        set_irq(64'h0000_0100_0000_0000 | 64'h0000_0000_0020_0000);
        all_state("R10");

        // R9: no pending source drops the request
        set_irq(64'h0);
        all_state("R9");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule